// File: doc/BRIEF.md
# Cascaded Two-Stage Pacer Programmer

This block sets up a long-period pacing clock built from two 16-bit rate-generator counters wired in series. The first stage runs on the base clock, and its terminal pulse clocks the second stage. The resulting pacer period is the product of the two divisors. The block does not hold the counters itself. It drives them through a byte-wide programming port: a two-bit address picks a counter data register (0..2) or the control register (3), and a valid/ready handshake carries one byte per accepted cycle.

Software-side logic first places two pending divisors into a staging pair. An explicit update step then copies them into the active pair. An enable request walks a fixed sequence in this order:
- a control word to each stage;
- the second-stage divisor;
- the first-stage divisor.

Loading the second stage first means the first stage can never expire into an unprepared successor. A disable request instead sends each stage a control word that parks it in mode 0, and it loads no divisor. While the pacer runs, the counters it uses are marked busy, and a general-purpose access check refuses them.

Top module: `pacer_cascade_ctrl`

## Requirements
- R1: An enable sequence starts with two control writes at address 3: first for the stage-one counter, then for the stage-two counter. The control byte is `{counter[1:0], 2'b11, mode[2:0], 1'b0}`, with mode 3'b010 (rate generator, binary count) on enable.
- R2: After its control writes, an enable loads the stage-two active divisor and then the stage-one active divisor. Each divisor goes to the address equal to its counter index, low byte first and high byte second. The sequence is six transactions in total.
- R3: A disable sequence is exactly two control writes at address 3, stage one then stage two, with mode 3'b000 (bytes 0x30 | counter<<6). It makes no data writes.
- R4: Active divisors change only on an update request made while idle. Each takes the low 16 bits of its 17-bit pending value, so a pending 65536 becomes 0x0000. Pending writes without an update leave the bytes of the next enable unchanged.
- R5: A request is rejected if the two stage selects are equal or if either is above 2. A rejected request raises reqReject for one cycle, starting one cycle after the request, and issues no transaction.
- R6: Accepting an enable sets busyMask to exactly the two selected counters. A completed disable clears busyMask. A general-purpose query answers one cycle later: gpDeny if the counter is busy or its index is above 2, otherwise gpGrant.
- R7: Exactly one transaction is consumed per cycle in which progValid and progReady are both high. While progReady is low, progAddr and progData hold their values, and the sequence still completes with the same bytes.
- R8: seqDone is a single-cycle pulse, visible in the cycle after the final transaction of an enable or disable is accepted.
- R9: Enable, disable and update requests that arrive while a sequence is in progress are ignored.
- R10: With both stages running, the stage-two terminal pulses repeat every d1 × d2 base clock cycles.
- R11: After reset, progValid, seqActive, seqDone and reqReject are low, busyMask is 0, and both active divisors are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pendWr | input | 1 | Write both pending divisors |
| pendDiv1In | input | 17 | Stage-one pending divisor (1..65536) |
| pendDiv2In | input | 17 | Stage-two pending divisor (1..65536) |
| updateReq | input | 1 | Copy pending divisors to active divisors |
| stage1Sel | input | 2 | Counter index used as stage one |
| stage2Sel | input | 2 | Counter index used as stage two |
| enableReq | input | 1 | Start enable sequence |
| disableReq | input | 1 | Start disable sequence |
| progValid | output | 1 | Programming byte available |
| progReady | input | 1 | Programming byte accepted |
| progAddr | output | 2 | 0..2 counter data, 3 control |
| progData | output | 8 | Programming byte |
| seqDone | output | 1 | Sequence finished pulse |
| reqReject | output | 1 | Invalid selects pulse |
| seqActive | output | 1 | Sequence in progress |
| busyMask | output | 3 | Counters reserved by the pacer |
| gpReq | input | 1 | General-purpose access query |
| gpCtr | input | 2 | Counter index of the query |
| gpGrant | output | 1 | Query granted |
| gpDeny | output | 1 | Query refused |

## Verification
If a request is captured on edge k, its first transaction goes out on edge k+1, provided progReady is held high. The last transaction goes out on edge k+6 for an enable and k+2 for a disable. seqDone, reqReject and the gp answers are registered, so each is due exactly one edge after its cause. The bench drives inputs and samples outputs at falling edges, and it logs each accepted byte at the rising edge where it is taken. The checks therefore compare whole logged sequences rather than guessing individual cycles. The pulse checks look at the first falling edge after the cause and again at the one after it. The period check runs a behavioural model of the two counters from the logged bytes and measures the gap between successive stage-two pulses.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int SEL_W  = 2;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 16;
  localparam int PEND_W = DIV_W + 1;
  localparam logic [2:0] MODE_RATE = 3'b010;
  localparam logic [2:0] MODE_PARK = 3'b000;

  typedef struct packed {
    logic       capture;
    logic       isEnable;
    logic       latchActive;
    logic       setBusy;
    logic       clrBusy;
    logic [2:0] step;
  } ctlStrobes_t;

  function automatic logic [BYTE_W-1:0] ctrlWord(input logic [SEL_W-1:0] ctr,
                                                 input logic runMode);
    return {ctr, 2'b11, (runMode ? MODE_RATE : MODE_PARK), 1'b0};
  endfunction
endpackage

// File: rtl/pacer_seq.sv
module pacer_seq
  import pacer_pkg::*;
#(
  parameter int NUM_CTR = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enableReq,
  input  logic             disableReq,
  input  logic             updateReq,
  input  logic [SEL_W-1:0] stage1Sel,
  input  logic [SEL_W-1:0] stage2Sel,
  input  logic             progReady,
  output logic             progValid,
  output logic             seqDone,
  output logic             reqReject,
  output logic             seqActive,
  output ctlStrobes_t      ctl
);
  localparam logic [SEL_W-1:0] LAST_CTR = SEL_W'(NUM_CTR - 1);
  localparam logic [2:0] LAST_EN  = 3'd5;
  localparam logic [2:0] LAST_DIS = 3'd1;

  logic       running;
  logic       isEn;
  logic [2:0] step;
  logic       doneQ;
  logic       rejQ;
  logic       selOk;
  logic       anyReq;
  logic [2:0] lastStep;
  logic       finalBeat;

  assign selOk     = (stage1Sel <= LAST_CTR) && (stage2Sel <= LAST_CTR) &&
                     (stage1Sel != stage2Sel);
  assign anyReq    = enableReq || disableReq;
  assign lastStep  = isEn ? LAST_EN : LAST_DIS;
  assign finalBeat = running && progReady && (step == lastStep);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      isEn    <= 1'b0;
      step    <= '0;
      doneQ   <= 1'b0;
      rejQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      rejQ  <= 1'b0;
      if (!running) begin
        if (anyReq) begin
          if (selOk) begin
            running <= 1'b1;
            isEn    <= enableReq;
            step    <= '0;
          end else begin
            rejQ <= 1'b1;
          end
        end
      end else if (progReady) begin
        if (step == lastStep) begin
          running <= 1'b0;
          doneQ   <= 1'b1;
          step    <= '0;
        end else begin
          step <= step + 3'd1;
        end
      end
    end
  end

  always_comb begin
    ctl.capture     = !running && anyReq && selOk;
    ctl.isEnable    = isEn;
    ctl.latchActive = !running && updateReq;
    ctl.setBusy     = !running && enableReq && selOk;
    ctl.clrBusy     = finalBeat && !isEn;
    ctl.step        = step;
  end

  assign progValid = running;
  assign seqActive = running;
  assign seqDone   = doneQ;
  assign reqReject = rejQ;

  // R7: a stalled byte stays offered at the same step
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    progValid && !progReady |=> progValid && $stable(ctl.step));
  // R8: done only follows an accepted transaction
  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seqDone |-> $past(progValid && progReady));
  // R5: a rejection never coincides with a running sequence
  p_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reqReject |-> !progValid);
  // R3: a park sequence never reaches a data step
  p_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
    progValid && !ctl.isEnable |-> ctl.step <= LAST_DIS);
endmodule

// File: rtl/pacer_regs.sv
module pacer_regs
  import pacer_pkg::*;
#(
  parameter int NUM_CTR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       ctl,
  input  logic              pendWr,
  input  logic [PEND_W-1:0] pendDiv1In,
  input  logic [PEND_W-1:0] pendDiv2In,
  input  logic [SEL_W-1:0]  stage1Sel,
  input  logic [SEL_W-1:0]  stage2Sel,
  input  logic              gpReq,
  input  logic [SEL_W-1:0]  gpCtr,
  output logic [SEL_W-1:0]  progAddr,
  output logic [BYTE_W-1:0] progData,
  output logic [NUM_CTR-1:0] busyMask,
  output logic              gpGrant,
  output logic              gpDeny
);
  localparam logic [SEL_W-1:0] CTRL_ADDR = SEL_W'((1 << SEL_W) - 1);
  localparam logic [PEND_W-1:0] FULL_SCALE = PEND_W'(1 << DIV_W);

  logic [PEND_W-1:0] pend1Q, pend2Q;
  logic [DIV_W-1:0]  act1Q, act2Q;
  logic [SEL_W-1:0]  s1Q, s2Q;
  logic [NUM_CTR-1:0] busyQ;
  logic [NUM_CTR-1:0] freeHit;
  logic grantQ, denyQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend1Q <= '0;
      pend2Q <= '0;
      act1Q  <= '0;
      act2Q  <= '0;
      s1Q    <= '0;
      s2Q    <= '0;
      grantQ <= 1'b0;
      denyQ  <= 1'b0;
    end else begin
      if (pendWr) begin
        pend1Q <= pendDiv1In;
        pend2Q <= pendDiv2In;
      end
      if (ctl.latchActive) begin
        act1Q <= pend1Q[DIV_W-1:0];
        act2Q <= pend2Q[DIV_W-1:0];
      end
      if (ctl.capture) begin
        s1Q <= stage1Sel;
        s2Q <= stage2Sel;
      end
      grantQ <= gpReq && (|freeHit);
      denyQ  <= gpReq && !(|freeHit);
    end
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_busy
    localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n)
        busyQ[g] <= 1'b0;
      else if (ctl.setBusy)
        busyQ[g] <= (stage1Sel == IDX) || (stage2Sel == IDX);
      else if (ctl.clrBusy)
        busyQ[g] <= 1'b0;
    end
    assign freeHit[g] = (gpCtr == IDX) && !busyQ[g];
  end

  always_comb begin
    progAddr = CTRL_ADDR;
    progData = ctrlWord(s1Q, ctl.isEnable);
    case (ctl.step)
      3'd1: progData = ctrlWord(s2Q, ctl.isEnable);
      3'd2: begin progAddr = s2Q; progData = act2Q[7:0];  end
      3'd3: begin progAddr = s2Q; progData = act2Q[15:8]; end
      3'd4: begin progAddr = s1Q; progData = act1Q[7:0];  end
      3'd5: begin progAddr = s1Q; progData = act1Q[15:8]; end
      default: ;
    endcase
  end

  assign busyMask = busyQ;
  assign gpGrant  = grantQ;
  assign gpDeny   = denyQ;

  // R4: active divisors move only on a latch strobe
  p_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.latchActive |=> $stable(act1Q) && $stable(act2Q));
  // R4: full-scale pending value folds to zero
  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.latchActive && pend1Q == FULL_SCALE |=> act1Q == '0);
  // R6: an answer needs a query one cycle earlier and is never both
  p_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gpGrant || gpDeny) |-> $past(gpReq) && !(gpGrant && gpDeny));
  // R6: a running pacer holds two reserved counters
  p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.setBusy |=> $countones(busyMask) == 2);
endmodule

// File: rtl/pacer_cascade_ctrl.sv
module pacer_cascade_ctrl
  import pacer_pkg::*;
#(
  parameter int NUM_CTR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pendWr,
  input  logic [16:0]       pendDiv1In,
  input  logic [16:0]       pendDiv2In,
  input  logic              updateReq,
  input  logic [1:0]        stage1Sel,
  input  logic [1:0]        stage2Sel,
  input  logic              enableReq,
  input  logic              disableReq,
  output logic              progValid,
  input  logic              progReady,
  output logic [1:0]        progAddr,
  output logic [7:0]        progData,
  output logic              seqDone,
  output logic              reqReject,
  output logic              seqActive,
  output logic [NUM_CTR-1:0] busyMask,
  input  logic              gpReq,
  input  logic [1:0]        gpCtr,
  output logic              gpGrant,
  output logic              gpDeny
);
  ctlStrobes_t ctl;

  pacer_seq #(.NUM_CTR(NUM_CTR)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .enableReq(enableReq), .disableReq(disableReq), .updateReq(updateReq),
    .stage1Sel(stage1Sel), .stage2Sel(stage2Sel),
    .progReady(progReady), .progValid(progValid),
    .seqDone(seqDone), .reqReject(reqReject), .seqActive(seqActive),
    .ctl(ctl)
  );

  pacer_regs #(.NUM_CTR(NUM_CTR)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .pendWr(pendWr), .pendDiv1In(pendDiv1In), .pendDiv2In(pendDiv2In),
    .stage1Sel(stage1Sel), .stage2Sel(stage2Sel),
    .gpReq(gpReq), .gpCtr(gpCtr),
    .progAddr(progAddr), .progData(progData),
    .busyMask(busyMask), .gpGrant(gpGrant), .gpDeny(gpDeny)
  );
endmodule

// File: tb/pacer_cascade_ctrl_test.sv
module pacer_cascade_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pendWr = 1'b0, updateReq = 1'b0, enableReq = 1'b0, disableReq = 1'b0;
  logic [16:0] pendDiv1In = '0, pendDiv2In = '0;
  logic [1:0] stage1Sel = 2'd0, stage2Sel = 2'd1;
  logic progValid, progReady = 1'b1;
  logic [1:0] progAddr;
  logic [7:0] progData;
  logic seqDone, reqReject, seqActive;
  logic [2:0] busyMask;
  logic gpReq = 1'b0;
  logic [1:0] gpCtr = 2'd0;
  logic gpGrant, gpDeny;

  pacer_cascade_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pendWr(pendWr), .pendDiv1In(pendDiv1In),
    .pendDiv2In(pendDiv2In), .updateReq(updateReq), .stage1Sel(stage1Sel),
    .stage2Sel(stage2Sel), .enableReq(enableReq), .disableReq(disableReq),
    .progValid(progValid), .progReady(progReady), .progAddr(progAddr),
    .progData(progData), .seqDone(seqDone), .reqReject(reqReject),
    .seqActive(seqActive), .busyMask(busyMask), .gpReq(gpReq), .gpCtr(gpCtr),
    .gpGrant(gpGrant), .gpDeny(gpDeny)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChk = 0, nBad = 0, cyc = 0, txN = 0;
  logic [1:0] txA [0:255];
  logic [7:0] txD [0:255];
  // behavioural counter model fed by the logged bytes
  int mCnt [0:2], mRel [0:2];
  bit mRun [0:2], mM2 [0:2], mPh [0:2];
  logic [7:0] mLo [0:2];
  int mS1 = 0, mS2 = 1;
  int pulseN = 0, lastP = 0, prevP = 0;
  bit tick1;

  initial begin
    for (int i = 0; i < 3; i++) begin
      mCnt[i] = 0; mRel[i] = 0; mRun[i] = 0; mM2[i] = 0; mPh[i] = 0; mLo[i] = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    tick1 = 0;
    if (mRun[mS1] && mM2[mS1]) begin
      if (mCnt[mS1] == 1) begin mCnt[mS1] = mRel[mS1]; tick1 = 1; end
      else mCnt[mS1]--;
    end
    if (tick1 && mRun[mS2] && mM2[mS2]) begin
      if (mCnt[mS2] == 1) begin
        mCnt[mS2] = mRel[mS2]; prevP = lastP; lastP = cyc; pulseN++;
      end else mCnt[mS2]--;
    end
    if (rst_n && progValid && progReady) begin
      if (txN < 256) begin txA[txN] = progAddr; txD[txN] = progData; end
      txN++;
      if (progAddr == 2'd3) begin
        mRun[progData[7:6]] = 0; mPh[progData[7:6]] = 0;
        mM2[progData[7:6]] = (progData[3:1] == 3'b010);
      end else if (!mPh[progAddr]) begin
        mLo[progAddr] = progData; mPh[progAddr] = 1;
      end else begin
        mRel[progAddr] = ({progData, mLo[progAddr]} == 16'h0) ? 65536 : int'({progData, mLo[progAddr]});
        mCnt[progAddr] = mRel[progAddr]; mRun[progAddr] = 1; mPh[progAddr] = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cw(input int ctr, input bit run);
    return 8'((ctr << 6) | 8'h30 | (run ? 8'h04 : 8'h00));
  endfunction

  task automatic setDivs(input int d1, input int d2, input bit doUpd);
    @(negedge clk);
    pendDiv1In = 17'(d1); pendDiv2In = 17'(d2); pendWr = 1'b1;
    @(negedge clk);
    pendWr = 1'b0; updateReq = doUpd;
    @(negedge clk);
    updateReq = 1'b0;
  endtask

  task automatic issue(input bit en, input int s1, input int s2);
    @(negedge clk);
    stage1Sel = 2'(s1); stage2Sel = 2'(s2); enableReq = en; disableReq = !en;
    @(negedge clk);
    enableReq = 1'b0; disableReq = 1'b0;
  endtask

  // waits for done; checks the expected byte count and single-cycle pulse (R8)
  task automatic waitDone(input int base, input int expN, input string req);
    int k = 0;
    while (!seqDone && k < 400) begin @(negedge clk); k++; end
    check(seqDone == 1'b1, "R8 done seen", int'(seqDone), 1);
    check(txN - base == expN, req, txN - base, expN);
    @(negedge clk);
    check(seqDone == 1'b0, "R8 done single cycle", int'(seqDone), 0);
  endtask

  task automatic expectEnable(input int base, input int s1, input int s2,
                              input int d1, input int d2, input string tag);
    logic [1:0] ea [0:5];
    logic [7:0] ed [0:5];
    ea[0] = 2'd3; ed[0] = cw(s1, 1);
    ea[1] = 2'd3; ed[1] = cw(s2, 1);
    ea[2] = 2'(s2); ed[2] = 8'(d2);
    ea[3] = 2'(s2); ed[3] = 8'(d2 >> 8);
    ea[4] = 2'(s1); ed[4] = 8'(d1);
    ea[5] = 2'(s1); ed[5] = 8'(d1 >> 8);
    for (int i = 0; i < 6; i++) begin
      check(txA[base+i] == ea[i], {tag, " addr"}, int'(txA[base+i]), int'(ea[i]));
      check(txD[base+i] == ed[i], {tag, " data"}, int'(txD[base+i]), int'(ed[i]));
    end
  endtask

  task automatic testEnable(input int s1, input int s2, input int d1, input int d2);
    int base;
    setDivs(d1, d2, 1'b1);
    mS1 = s1; mS2 = s2;
    base = txN;
    issue(1'b1, s1, s2);
    check(busyMask == 3'((1 << s1) | (1 << s2)), "R6 busy set", int'(busyMask), (1 << s1) | (1 << s2));
    waitDone(base, 6, "R2 enable count");
    expectEnable(base, s1, s2, d1, d2, "R1 R2 enable bytes");
    begin
      int snap = pulseN;
      int k = 0;
      while (pulseN < snap + 2 && k < 5000) begin @(negedge clk); k++; end
      check(lastP - prevP == d1 * d2, "R10 pacer period", lastP - prevP, d1 * d2);
    end
  endtask

  task automatic testDisable(input int s1, input int s2);
    int base = txN;
    issue(1'b0, s1, s2);
    waitDone(base, 2, "R3 disable count");
    check(txA[base] == 2'd3 && txD[base] == cw(s1, 0), "R3 park stage one", int'(txD[base]), int'(cw(s1, 0)));
    check(txA[base+1] == 2'd3 && txD[base+1] == cw(s2, 0), "R3 park stage two", int'(txD[base+1]), int'(cw(s2, 0)));
    check(busyMask == 3'b000, "R6 busy cleared", int'(busyMask), 0);
  endtask

  task automatic gpQuery(input int ctr, input bit expGrant);
    @(negedge clk);
    gpReq = 1'b1; gpCtr = 2'(ctr);
    @(negedge clk);
    gpReq = 1'b0;
    check(gpGrant == expGrant && gpDeny == !expGrant, "R6 gp answer",
          int'({gpGrant, gpDeny}), int'({expGrant, !expGrant}));
  endtask

  task automatic testReject(input bit en, input int s1, input int s2);
    int base = txN;
    issue(en, s1, s2);
    check(reqReject == 1'b1, "R5 reject pulse", int'(reqReject), 1);
    @(negedge clk);
    check(reqReject == 1'b0, "R5 reject single cycle", int'(reqReject), 0);
    repeat (4) @(negedge clk);
    check(txN == base && !seqActive, "R5 no transactions", txN - base, 0);
  endtask

  task automatic testMask;
    int base;
    setDivs(4, 2, 1'b1);
    setDivs(65536, 16'h1234, 1'b0);
    base = txN;
    issue(1'b1, 0, 1);
    waitDone(base, 6, "R4 enable count");
    expectEnable(base, 0, 1, 4, 2, "R4 pending without update");
    setDivs(65536, 16'h1234, 1'b1);
    base = txN;
    issue(1'b1, 0, 1);
    waitDone(base, 6, "R4 enable count");
    expectEnable(base, 0, 1, 0, 16'h1234, "R4 masked full scale");
    testDisable(0, 1);
  endtask

  task automatic testStall;
    int base;
    int k = 0;
    setDivs(16'h0203, 16'h0405, 1'b1);
    base = txN;
    issue(1'b1, 1, 2);
    while (!seqDone && k < 400) begin
      progReady = (k % 3 == 2);
      @(negedge clk);
      if (progValid && !progReady) begin
        logic [7:0] held = progData;
        @(negedge clk);
        k++;
        progReady = (k % 3 == 2);
        check(progData == held, "R7 stalled byte stable", int'(progData), int'(held));
      end
      k++;
    end
    progReady = 1'b1;
    check(txN - base == 6, "R7 count under stall", txN - base, 6);
    expectEnable(base, 1, 2, 16'h0203, 16'h0405, "R7 bytes under stall");
    @(negedge clk);
    testDisable(1, 2);
  endtask

  task automatic testIgnore;
    int base;
    setDivs(6, 7, 1'b1);
    setDivs(9, 9, 1'b0);
    progReady = 1'b0;
    base = txN;
    issue(1'b1, 0, 1);
    stage1Sel = 2'd2; stage2Sel = 2'd0; disableReq = 1'b1; updateReq = 1'b1;
    @(negedge clk);
    disableReq = 1'b0; updateReq = 1'b0;
    check(reqReject == 1'b0, "R9 no reject mid sequence", int'(reqReject), 0);
    progReady = 1'b1;
    waitDone(base, 6, "R9 count");
    expectEnable(base, 0, 1, 6, 7, "R9 first run");
    base = txN;
    issue(1'b1, 0, 1);
    waitDone(base, 6, "R9 count");
    expectEnable(base, 0, 1, 6, 7, "R9 update ignored");
    testDisable(0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nBad++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!progValid && !seqActive, "R11 idle after reset", int'({progValid, seqActive}), 0);
    check(!seqDone && !reqReject, "R11 pulses low after reset", int'({seqDone, reqReject}), 0);
    check(busyMask == 3'b000, "R11 busy clear", int'(busyMask), 0);
    begin
      int base = txN;
      issue(1'b1, 0, 1);
      waitDone(base, 6, "R11 enable count");
      expectEnable(base, 0, 1, 0, 0, "R11 active zero after reset");
      testDisable(0, 1);
    end

    testEnable(0, 1, 3, 5);
    gpQuery(0, 1'b0);
    gpQuery(2, 1'b1);
    gpQuery(3, 1'b0);
    testDisable(0, 1);
    gpQuery(0, 1'b1);

    testEnable(2, 0, 4, 2);
    gpQuery(2, 1'b0);
    testDisable(2, 0);

    testReject(1'b1, 1, 1);
    testReject(1'b1, 3, 0);
    testReject(1'b0, 0, 3);

    testMask();
    testStall();
    testIgnore();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule